// File: doc/BRIEF.md
# Cyclic Unpack Write-Address Generator

This block drives the destination side of an unpack command that moves packed vector elements into a vector memory. When a command starts, it captures the command fields. It reports how many 32-bit operand words the command will consume from the instruction stream. It then steps through the output vectors, one per clock. For each vector it gives the byte address in vector memory and flags whether the vector receives filler data instead of consumed data. It also widens the packed elements of the current input vector into four 32-bit lanes.

Two cyclic patterns are supported through a cycle length and a write length. When the write length does not exceed the cycle length, the block skips addresses. Each group of write-length vectors lands at the start of a cycle-length stride, and a write length of zero counts as 256. When the cycle length is shorter than the write length, addresses run linearly and the tail of each write-length group is marked as filler. An optional double-buffer offset is added after the cyclic offset. The result wraps inside a memory window given by a base and a size. The memory write itself, and the supply of filler values, are left to the surrounding logic.

Top module: `unpk_addr_gen`

## Requirements
- R1: After reset, vec_valid and done are low and op_words is zero.
- R2: On an accepted start, op_words becomes ceil(E*(vn+1)*n/32), where E = 32>>vl and n is the input vector count. n equals count when wl is zero or wl <= cl. Otherwise n = cl*floor(count/wl) + min(count mod wl, cl). op_words holds until the next accepted start.
- R3: An accepted start with count > 0 gives exactly count cycles of vec_valid, starting in the cycle after the start edge, with output vector index k = 0, 1, ... in order. done pulses for one cycle right after the last of them. With count = 0, including the all-zero clear-only command, done pulses in the cycle after start and vec_valid stays low.
- R4: In skip mode (wl = 0 or wl <= cl, with wl = 0 counted as 256), the pre-wrap offset of vector k is imm + floor(k/wl)*cl + (k mod wl) vector slots.
- R5: In fill mode (cl < wl), the pre-wrap offset of vector k is imm + k. vec_fill is high exactly when (k mod wl) >= cl.
- R6: When the double-buffer bit was set at start, the top value is added to the slot offset after the cyclic term.
- R7: vec_addr = mem_base + ((16 * slot offset) mod mem_size) when mem_size is nonzero. When mem_size is zero, vec_addr = mem_base + 16 * slot offset with no wrap.
- R8: For a non-filler vector, lane i (lanes[32*i+31:32*i]) holds packed element i. That element is pkd_vec bits [i*E+E-1 : i*E]. It is sign-extended from bit E-1, or zero-extended when usn was set at start. Lanes with i > vn are zero.
- R9: During a filler vector, and whenever vec_valid is low, all lanes are zero.
- R10: A start that arrives while a command is in progress is ignored, and the running sequence is unchanged.
- R11: All command fields are captured on the start edge. Changes to them during a command have no effect on that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command (accepted only when idle) |
| count | input | NUM_W | Number of output vectors |
| imm | input | IMM_W | Starting slot offset (16-byte slots) |
| cl | input | NUM_W | Cycle length |
| wl | input | NUM_W | Write length (0 counts as 256) |
| vl | input | 2 | Element size code: element width 32>>vl |
| vn | input | 2 | Component count minus one |
| usn | input | 1 | Zero-extend elements instead of sign-extending |
| dbuf | input | 1 | Add double-buffer top offset |
| dbl_top | input | TOP_W | Double-buffer top, in slots |
| mem_base | input | ADDR_W | Byte base of the memory window |
| mem_size | input | ADDR_W | Byte size of the memory window |
| pkd_vec | input | 128 | Packed elements of the current input vector |
| op_words | output | OPW_W | Operand words consumed by the command |
| vec_valid | output | 1 | An output vector is presented this cycle |
| vec_addr | output | ADDR_W | Byte address of the output vector |
| vec_fill | output | 1 | Output vector takes filler data |
| lanes | output | 128 | Four expanded 32-bit lanes |
| done | output | 1 | One-cycle pulse after the last vector |

## Verification
Directed commands separate the two cyclic regimes. A skip-mode stride with cl=4 and wl=2 must jump addresses, while a fill-mode pattern with cl=1 and wl=3 must mark two of every three vectors as filler at linear addresses. Further directed commands cover wl=0 and equal cl and wl. One command uses a small window that forces wraparound, and another adds the double-buffer offset. The all-zero clear-only command is tried, and so is a start pulsed mid-command. Constrained random commands then mix every element size, component count and sign mode over random bases and window sizes. For the lanes, 4-bit signed elements show sign extension at the narrowest width, and lanes above vn show the zero fill. The fields are scrambled after each start to expose any late sampling.

// File: rtl/unpk_pkg.sv
// Package: shared constants and helpers for the unpack address generator.
// Assumes four lanes of 32 bits each; element width is LANE_W >> vl.
package unpk_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 32;
    localparam int PK_W   = LANES * LANE_W;

    // Address pattern chosen from the cycle and write lengths.
    typedef enum logic {
        PAT_SKIP = 1'b0,
        PAT_FILL = 1'b1
    } pat_e;
endpackage

// File: rtl/unpk_count.sv
// unpk_count: combinational operand-word count for one unpack command.
// Assumes wl==0 means 256 (skip pattern), so division by wl only occurs
// in the fill pattern where wl > cl >= 0 and wl is nonzero.
module unpk_count #(
    parameter int NUM_W = 8,
    parameter int OPW_W = 10
) (
    input  logic [NUM_W-1:0] num,
    input  logic [NUM_W-1:0] cl,
    input  logic [NUM_W-1:0] wl,
    input  logic [1:0]       vl,
    input  logic [1:0]       vn,
    output logic [OPW_W-1:0] words
);
    import unpk_pkg::*;

    localparam int NB = NUM_W + 8;

    logic             skip;
    logic [NUM_W-1:0] wl_div;
    logic [NUM_W-1:0] quo;
    logic [NUM_W-1:0] rem;
    logic [NUM_W-1:0] tail;
    logic [2*NUM_W-1:0] n_full;
    logic [NB-1:0]    bits;
    logic [NB-1:0]    ew;

    // Input vector count n from the cyclic pattern.
    always_comb begin
        skip   = (wl == '0) || (wl <= cl);
        wl_div = (wl == '0) ? NUM_W'(1) : wl;
        quo    = num / wl_div;
        rem    = num % wl_div;
        tail   = (rem < cl) ? rem : cl;
        if (skip)
            n_full = (2*NUM_W)'(num);
        else
            n_full = (2*NUM_W)'(cl) * (2*NUM_W)'(quo) + (2*NUM_W)'(tail);
    end

    // Bits consumed, rounded up to whole 32-bit words.
    always_comb begin
        ew    = NB'(LANE_W) >> vl;
        bits  = ew * (NB'(vn) + NB'(1)) * NB'(n_full);
        words = OPW_W'((bits + NB'(31)) >> 5);
    end
endmodule

// File: rtl/unpk_lane.sv
// unpk_lane: widens packed elements into LANES 32-bit lanes.
// Assumes element i sits at bit i*E of the packed word, E = LANE_W >> vl.
module unpk_lane (
    input  logic [1:0]               vl,
    input  logic [1:0]               vn,
    input  logic                     usn,
    input  logic                     blank,
    input  logic [unpk_pkg::PK_W-1:0] pkd,
    output logic [unpk_pkg::PK_W-1:0] lanes
);
    import unpk_pkg::*;

    localparam int W1 = LANE_W / 2;
    localparam int W2 = LANE_W / 4;
    localparam int W3 = LANE_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] ext;

        // Pick the element at the coded width and extend it to a lane.
        always_comb begin
            unique case (vl)
                2'd0: ext = pkd[LANE_W*i +: LANE_W];
                2'd1: ext = usn ? LANE_W'(pkd[W1*i +: W1])
                                : {{(LANE_W-W1){pkd[W1*i+W1-1]}}, pkd[W1*i +: W1]};
                2'd2: ext = usn ? LANE_W'(pkd[W2*i +: W2])
                                : {{(LANE_W-W2){pkd[W2*i+W2-1]}}, pkd[W2*i +: W2]};
                default: ext = usn ? LANE_W'(pkd[W3*i +: W3])
                                   : {{(LANE_W-W3){pkd[W3*i+W3-1]}}, pkd[W3*i +: W3]};
            endcase
        end

        // Zero lanes past the component count or when blanked.
        assign lanes[LANE_W*i +: LANE_W] =
            (blank || (i > int'(vn))) ? '0 : ext;
    end
endmodule

// File: rtl/unpk_seq.sv
// unpk_seq: captures the command and walks the output vectors, one per
// cycle, producing address, filler flag and the done pulse.
// Assumes mem_base + mem_size fits in ADDR_W bits; k/wl and k%wl are kept
// as running counters so no divider sits on the per-vector path.
module unpk_seq #(
    parameter int NUM_W  = 8,
    parameter int IMM_W  = 10,
    parameter int TOP_W  = 10,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_W-1:0]  count,
    input  logic [IMM_W-1:0]  imm,
    input  logic [NUM_W-1:0]  cl,
    input  logic [NUM_W-1:0]  wl,
    input  logic [1:0]        vl,
    input  logic [1:0]        vn,
    input  logic              usn,
    input  logic              dbuf,
    input  logic [TOP_W-1:0]  dbl_top,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] mem_size,
    output logic              busy,
    output logic              accept,
    output logic              done,
    output logic [ADDR_W-1:0] addr,
    output logic              fill,
    output logic [1:0]        c_vl,
    output logic [1:0]        c_vn,
    output logic              c_usn
);
    import unpk_pkg::*;

    localparam int CYC_W = 2 * NUM_W;

    logic [NUM_W-1:0]  c_count, c_cl, c_wl;
    logic [IMM_W-1:0]  c_imm;
    logic              c_dbuf;
    logic [TOP_W-1:0]  c_top;
    logic [ADDR_W-1:0] c_base, c_size;
    pat_e              c_pat;

    logic [NUM_W-1:0]  k;
    logic [NUM_W-1:0]  pos;
    logic [CYC_W-1:0]  cyc;
    logic [NUM_W-1:0]  pos_last;
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] rel_w;

    assign accept   = start && !busy;
    assign pos_last = (c_wl == '0) ? {NUM_W{1'b1}} : c_wl - NUM_W'(1);

    // Capture the command on an accepted start and step the vector counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            k       <= '0;
            pos     <= '0;
            cyc     <= '0;
            c_count <= '0;
            c_cl    <= '0;
            c_wl    <= '0;
            c_imm   <= '0;
            c_vl    <= '0;
            c_vn    <= '0;
            c_usn   <= 1'b0;
            c_dbuf  <= 1'b0;
            c_top   <= '0;
            c_base  <= '0;
            c_size  <= '0;
            c_pat   <= PAT_SKIP;
        end else begin
            done <= 1'b0;
            if (accept) begin
                c_count <= count;
                c_cl    <= cl;
                c_wl    <= wl;
                c_imm   <= imm;
                c_vl    <= vl;
                c_vn    <= vn;
                c_usn   <= usn;
                c_dbuf  <= dbuf;
                c_top   <= dbl_top;
                c_base  <= mem_base;
                c_size  <= mem_size;
                c_pat   <= ((wl == '0) || (wl <= cl)) ? PAT_SKIP : PAT_FILL;
                k       <= '0;
                pos     <= '0;
                cyc     <= '0;
                if (count != '0)
                    busy <= 1'b1;
                else
                    done <= 1'b1;
            end else if (busy) begin
                if (k == c_count - NUM_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    k <= k + NUM_W'(1);
                end
                if (pos == pos_last) begin
                    pos <= '0;
                    cyc <= cyc + CYC_W'(c_cl);
                end else begin
                    pos <= pos + NUM_W'(1);
                end
            end
        end
    end

    // Slot offset: cyclic or linear term, then the double-buffer top.
    always_comb begin
        offs = ADDR_W'(c_imm)
             + ((c_pat == PAT_SKIP) ? ADDR_W'(cyc) + ADDR_W'(pos) : ADDR_W'(k))
             + (c_dbuf ? ADDR_W'(c_top) : '0);
        rel   = offs << 4;
        rel_w = (c_size == '0) ? rel : rel % c_size;
        addr  = c_base + rel_w;
        fill  = busy && (c_pat == PAT_FILL) && (pos >= c_cl);
    end

    // R7: the address stays inside the window while a vector is presented.
    a_r7_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && c_size != '0) |-> (addr >= c_base) && ((addr - c_base) < c_size));

    // R5: filler is flagged only in the fill pattern with cl below wl.
    a_r5_fill_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> (busy && (c_cl < c_wl)));

    // R10, R11: captured fields do not move while a command runs.
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(c_cl) && $stable(c_wl) && $stable(c_imm) && $stable(c_base)));

    // R3: the vector index never runs past the command count.
    a_r3_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (k < c_count));
endmodule

// File: rtl/unpk_addr_gen.sv
// unpk_addr_gen: top of the cyclic unpack write-address generator.
// Reports the operand word count of each command, then presents one output
// vector per cycle with address, filler flag and expanded lanes.
// Assumes pkd_vec holds the current input vector during each valid cycle.
module unpk_addr_gen #(
    parameter int NUM_W  = 8,
    parameter int IMM_W  = 10,
    parameter int TOP_W  = 10,
    parameter int ADDR_W = 24,
    localparam int OPW_W = $clog2(((1 << NUM_W) - 1) * unpk_pkg::LANES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_W-1:0]           count,
    input  logic [IMM_W-1:0]           imm,
    input  logic [NUM_W-1:0]           cl,
    input  logic [NUM_W-1:0]           wl,
    input  logic [1:0]                 vl,
    input  logic [1:0]                 vn,
    input  logic                       usn,
    input  logic                       dbuf,
    input  logic [TOP_W-1:0]           dbl_top,
    input  logic [ADDR_W-1:0]          mem_base,
    input  logic [ADDR_W-1:0]          mem_size,
    input  logic [unpk_pkg::PK_W-1:0]  pkd_vec,
    output logic [OPW_W-1:0]           op_words,
    output logic                       vec_valid,
    output logic [ADDR_W-1:0]          vec_addr,
    output logic                       vec_fill,
    output logic [unpk_pkg::PK_W-1:0]  lanes,
    output logic                       done
);
    import unpk_pkg::*;

    logic [OPW_W-1:0] words_c;
    logic             busy, accept;
    logic [1:0]       c_vl, c_vn;
    logic             c_usn;

    unpk_count #(.NUM_W(NUM_W), .OPW_W(OPW_W)) u_count (
        .num   (count),
        .cl    (cl),
        .wl    (wl),
        .vl    (vl),
        .vn    (vn),
        .words (words_c)
    );

    unpk_seq #(.NUM_W(NUM_W), .IMM_W(IMM_W), .TOP_W(TOP_W), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .count    (count),
        .imm      (imm),
        .cl       (cl),
        .wl       (wl),
        .vl       (vl),
        .vn       (vn),
        .usn      (usn),
        .dbuf     (dbuf),
        .dbl_top  (dbl_top),
        .mem_base (mem_base),
        .mem_size (mem_size),
        .busy     (busy),
        .accept   (accept),
        .done     (done),
        .addr     (vec_addr),
        .fill     (vec_fill),
        .c_vl     (c_vl),
        .c_vn     (c_vn),
        .c_usn    (c_usn)
    );

    unpk_lane u_lane (
        .vl    (c_vl),
        .vn    (c_vn),
        .usn   (c_usn),
        .blank (!busy || vec_fill),
        .pkd   (pkd_vec),
        .lanes (lanes)
    );

    assign vec_valid = busy;

    // Hold the operand word count of the latest accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_words <= '0;
        else if (accept)
            op_words <= words_c;
    end

    // R9: filler vectors carry all-zero lanes.
    a_r9_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_fill) |-> (lanes == '0));

    // R3: done and a valid vector never share a cycle.
    a_r3_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && done));

    // R3: done follows directly on the last valid vector.
    a_r3_done_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vec_valid) |-> done);

    // R2: the reported word count holds while a command runs.
    a_r2_words_held: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> $stable(op_words));
endmodule

// File: tb/unpk_addr_gen_tb_top.sv
// Bench: directed corner cases plus seeded random commands, each vector
// compared against reference functions computed from the requirements.
module unpk_addr_gen_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   count = '0;
    logic [9:0]   imm = '0;
    logic [7:0]   cl = '0;
    logic [7:0]   wl = '0;
    logic [1:0]   vl = '0;
    logic [1:0]   vn = '0;
    logic         usn = 1'b0;
    logic         dbuf = 1'b0;
    logic [9:0]   dbl_top = '0;
    logic [23:0]  mem_base = '0;
    logic [23:0]  mem_size = '0;
    logic [127:0] pkd_vec = '0;
    logic [9:0]   op_words;
    logic         vec_valid;
    logic [23:0]  vec_addr;
    logic         vec_fill;
    logic [127:0] lanes;
    logic         done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    unpk_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count), .imm(imm),
        .cl(cl), .wl(wl), .vl(vl), .vn(vn), .usn(usn), .dbuf(dbuf),
        .dbl_top(dbl_top), .mem_base(mem_base), .mem_size(mem_size),
        .pkd_vec(pkd_vec), .op_words(op_words), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .vec_fill(vec_fill), .lanes(lanes), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ref_words(int c, int l, int w, int v, int m);
        int n;
        if (w == 0 || w <= l) n = c;
        else n = l * (c / w) + (((c % w) < l) ? (c % w) : l);
        return ((32 >> v) * (m + 1) * n + 31) / 32;
    endfunction

    function automatic logic [23:0] ref_addr(int k, int im, int l, int w, bit db,
                                             int tp, int bs, int sz);
        int we, offs, rel;
        we = (w == 0) ? 256 : w;
        if (w == 0 || w <= l) offs = im + (k / we) * l + (k % we);
        else offs = im + k;
        if (db) offs = offs + tp;
        rel = offs * 16;
        if (sz != 0) rel = rel % sz;
        return 24'(bs + rel);
    endfunction

    function automatic bit ref_fill(int k, int l, int w);
        return (w != 0) && (l < w) && ((k % w) >= l);
    endfunction

    function automatic logic [127:0] ref_lanes(logic [127:0] pk, int v, int m,
                                               bit u, bit fl);
        logic [127:0] r;
        int e;
        logic [31:0] x, msk;
        r = '0;
        e = 32 >> v;
        msk = (e == 32) ? 32'hFFFF_FFFF : ((32'd1 << e) - 32'd1);
        for (int i = 0; i < 4; i++) begin
            x = 32'(pk >> (i * e)) & msk;
            if (!u && x[e-1]) x = x | ~msk;
            if (fl || i > m) x = '0;
            r[32*i +: 32] = x;
        end
        return r;
    endfunction

    // Issue one command and compare every vector it produces.
    task automatic run_cmd(int c, int im, int l, int w, int v, int m, bit u,
                           bit db, int tp, int bs, int sz, bit restart);
        logic [127:0] el;
        bit fl;
        @(negedge clk);
        count = 8'(c); imm = 10'(im); cl = 8'(l); wl = 8'(w); vl = 2'(v);
        vn = 2'(m); usn = u; dbuf = db; dbl_top = 10'(tp);
        mem_base = 24'(bs); mem_size = 24'(sz); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        // R11: scramble the fields once they have been captured
        count = 8'($urandom); imm = 10'($urandom); cl = 8'($urandom);
        wl = 8'($urandom); vl = 2'($urandom); vn = 2'($urandom);
        usn = 1'($urandom); dbuf = 1'($urandom); dbl_top = 10'($urandom);
        mem_base = 24'($urandom); mem_size = 24'($urandom);
        if (c == 0) begin
            @(negedge clk);
            chk(done === 1'b1 && vec_valid === 1'b0, "R3 zero-count done",
                {done, vec_valid}, 2'b10);
            chk(op_words === 10'd0, "R2 zero-count words", op_words, 0);
        end else begin
            for (int k = 0; k < c; k++) begin
                pkd_vec = {$urandom, $urandom, $urandom, $urandom};
                if (restart && k == 0) start = 1'b1;   // R10 stray start
                @(negedge clk);
                fl = ref_fill(k, l, w);
                chk(vec_valid === 1'b1 && done === 1'b0, "R3 valid run",
                    {vec_valid, done}, 2'b10);
                chk(vec_addr === ref_addr(k, im, l, w, db, tp, bs, sz),
                    "R4/R5/R6/R7/R10 address", vec_addr,
                    ref_addr(k, im, l, w, db, tp, bs, sz));
                chk(vec_fill === fl, "R5 fill flag", vec_fill, fl);
                el = ref_lanes(pkd_vec, v, m, u, fl);
                chk(lanes === el, fl ? "R9 filler lanes" : "R8 lanes", lanes, el);
                if (k == 0)
                    chk(op_words === 10'(ref_words(c, l, w, v, m)), "R2 words",
                        op_words, ref_words(c, l, w, v, m));
                @(posedge clk); #1;
                start = 1'b0;
            end
            @(negedge clk);
            chk(done === 1'b1 && vec_valid === 1'b0, "R3 done pulse",
                {done, vec_valid}, 2'b10);
            chk(lanes === '0, "R9 idle lanes", lanes, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs at reset
        chk(vec_valid === 1'b0 && done === 1'b0 && op_words === 10'd0,
            "R1 reset state", {vec_valid, done, op_words}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R4 skip stride, R5 fill pattern, wl zero, equal lengths
        run_cmd(6, 5, 4, 2, 0, 3, 0, 0, 0, 24'h1000, 24'h100000, 0);
        run_cmd(7, 2, 1, 3, 1, 2, 0, 0, 0, 24'h2000, 24'h100000, 0);
        run_cmd(10, 9, 2, 0, 2, 1, 1, 0, 0, 24'h0, 24'h100000, 0);
        run_cmd(5, 0, 3, 3, 3, 3, 0, 0, 0, 24'h40, 24'h100000, 0);
        // R3 clear-only shortcut
        run_cmd(0, 0, 0, 0, 0, 0, 0, 0, 0, 24'h0, 24'h100000, 0);
        // R7 wraparound in a 4-slot window
        run_cmd(6, 3, 1, 1, 0, 0, 0, 0, 0, 24'h500, 24'h40, 0);
        // R6 double-buffer offset, R7 zero size
        run_cmd(4, 1, 2, 2, 1, 3, 1, 1, 17, 24'h300, 24'h0, 0);
        // R10 stray start during a command
        run_cmd(4, 7, 0, 2, 3, 3, 0, 0, 0, 24'h800, 24'h100000, 1);
        // R8 narrow signed elements, all lanes
        run_cmd(3, 0, 4, 4, 3, 3, 0, 0, 0, 24'h0, 24'h100000, 0);
        for (int t = 0; t < 60; t++) begin
            run_cmd(int'($urandom % 20), int'($urandom % 1024), int'($urandom % 6),
                    int'($urandom % 6), int'($urandom % 4), int'($urandom % 4),
                    1'($urandom), 1'($urandom), int'($urandom % 1024),
                    int'(($urandom % 65536) * 16),
                    int'(16 * (1 + $urandom % 64)), 1'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule